// File: doc/BRIEF.md
# Frame-Sync Register List Replayer

This block lets software stage a batch of register updates in memory and have them applied at the next frame boundary, so a display configuration change lands all at once instead of mid-frame. Each channel owns a table region in memory. A table is a run of two-word entries. The first word holds the word address of a target register and the second word holds the value to put there.

When a rising edge arrives on the frame sync input, every channel that has both its trigger-enable bit and its write-direction bit set becomes pending. The single fetch engine then serves the pending channels one at a time, lowest index first. For each channel it reads the table word by word from the inclusive range between the channel's start and end byte addresses. It issues one register write per complete entry. When a list is exhausted, the engine sets that channel's done flag, which raises the interrupt. Software acknowledges the flag by writing ones to the clear register. It normally drops the channel's trigger-enable bit at the same time so the list is not replayed on the following frame.

Top module: `vsync_reglist_dma`

## Requirements
- R1: Within an entry, the word at the lower memory address is the target register word address and the word 4 bytes above it is the value. Each entry yields exactly one write of that value to that address.
- R2: A channel reads memory words in ascending order from its start byte address to its end byte address inclusive, in steps of 4. Start is at configuration word 4+2*ch and end is at word 5+2*ch.
- R3: A channel becomes pending on a rising frame-sync edge only if two bits of the trigger register (configuration word 0) are set: bit ch (trigger enable) and bit NCH+ch (write direction). Without both, the edge causes no write and no done flag.
- R4: The target address of every write comes from its own entry. Consecutive writes need not be at consecutive addresses.
- R5: When a channel finishes its list, bit ch of the done register (configuration word 1) becomes 1 and the irq output is high while any done bit is set.
- R6: Writing configuration word 2 clears exactly the done bits at which the written data has a 1. The other bits are left unchanged, and irq falls once no done bit remains.
- R7: Channels armed on the same edge are served lowest index first, and each list completes before the next one begins.
- R8: A frame-sync edge that arrives while a channel is pending or running does not restart that channel or queue another run of it.
- R9: If the end address is below the start address, the channel makes no memory read and no write, and still sets its done bit.
- R10: After reset, there is no memory request, no write, irq is low and the done register reads zero.
- R11: A channel whose trigger-enable bit stays set replays its whole list on each later frame-sync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CAW | Configuration word index |
| cfg_wdata | input | DW | Configuration write data |
| cfg_rdata | output | DW | Configuration read data (combinational on cfg_addr) |
| vsync | input | 1 | Frame sync, rising edge triggers |
| mem_req | output | 1 | Memory read request, held until response |
| mem_addr | output | AW | Memory byte address of the requested word |
| mem_rvalid | input | 1 | Memory response valid, one cycle |
| mem_rdata | input | DW | Memory response data |
| wr_valid | output | 1 | Register write strobe |
| wr_addr | output | DW | Register word address |
| wr_data | output | DW | Register write value |
| irq | output | 1 | High while any done bit is set |

## Verification
A wrong fetch pointer shows up at the write port within one entry. The scoreboard sees a wrong address/value pair or a write that it did not expect, and the fetch-window property flags a request outside the channel's range on the same cycle. A pending or done flag that is lost or duplicated shows up as a missing or repeated list at the write port, or as a wrong done register a few cycles after the list drains. An error in arbitration order appears as the first write of the wrong channel directly after the frame-sync edge.

// File: rtl/rl_pkg.sv
package rl_pkg;
   typedef enum logic [1:0] {
      ENG_IDLE,
      ENG_ADDR,
      ENG_DATA
   } eng_state_t;

   localparam int REG_TRIG    = 0;
   localparam int REG_DONE    = 1;
   localparam int REG_CLR     = 2;
   localparam int REG_CH_BASE = 4;
endpackage

// File: rtl/rl_chan_cfg.sv
module rl_chan_cfg #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_start,
   input  logic          we_end,
   input  logic [DW-1:0] wdata,
   output logic [AW-1:0] start_addr,
   output logic [AW-1:0] end_addr
);
   localparam int CPW = (AW < DW) ? AW : DW;

   logic [AW-1:0] wval;
   always_comb begin
      wval = '0;
      wval[CPW-1:0] = wdata[CPW-1:0];
      wval[1:0] = 2'b00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_addr <= '0;
         end_addr   <= '0;
      end else begin
         if (we_start) start_addr <= wval;
         if (we_end)   end_addr   <= wval;
      end
   end
endmodule

// File: rtl/rl_arbiter.sv
module rl_arbiter #(
   parameter int NCH = 2,
   localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] req,
   output logic [NCH-1:0] grant,
   output logic [CW-1:0]  grant_idx
);
   always_comb begin
      grant     = '0;
      grant_idx = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant     = '0;
            grant[i]  = 1'b1;
            grant_idx = CW'(i);
         end
      end
   end

   // R7: at most one channel granted, and it is never one without a request
   a_r7_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~req) == '0));
endmodule

// File: rtl/rl_engine.sv
module rl_engine
   import rl_pkg::*;
#(
   parameter int AW  = 32,
   parameter int DW  = 32,
   parameter int NCH = 2,
   localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [CW-1:0] go_ch,
   input  logic [AW-1:0] go_start,
   input  logic [AW-1:0] go_end,
   output logic          busy,
   output logic [CW-1:0] cur_ch,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_rvalid,
   input  logic [DW-1:0] mem_rdata,
   output logic          wr_valid,
   output logic [DW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          fin,
   output logic [CW-1:0] fin_ch
);
   eng_state_t    state;
   logic [AW-1:0] ptr, last;
   logic [DW-1:0] reg_word;
   logic          at_last;

   assign busy     = (state != ENG_IDLE);
   assign mem_req  = busy;
   assign mem_addr = ptr;
   assign at_last  = (ptr == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ENG_IDLE;
         ptr      <= '0;
         last     <= '0;
         reg_word <= '0;
         cur_ch   <= '0;
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
         fin      <= 1'b0;
         fin_ch   <= '0;
      end else begin
         wr_valid <= 1'b0;
         fin      <= 1'b0;
         unique case (state)
            ENG_IDLE: if (go) begin
               cur_ch <= go_ch;
               ptr    <= go_start;
               last   <= go_end;
               if (go_end < go_start) begin
                  fin    <= 1'b1;
                  fin_ch <= go_ch;
               end else begin
                  state <= ENG_ADDR;
               end
            end
            ENG_ADDR: if (mem_rvalid) begin
               reg_word <= mem_rdata;
               if (at_last) begin
                  state  <= ENG_IDLE;
                  fin    <= 1'b1;
                  fin_ch <= cur_ch;
               end else begin
                  ptr   <= ptr + AW'(4);
                  state <= ENG_DATA;
               end
            end
            ENG_DATA: if (mem_rvalid) begin
               wr_valid <= 1'b1;
               wr_addr  <= reg_word;
               wr_data  <= mem_rdata;
               if (at_last) begin
                  state  <= ENG_IDLE;
                  fin    <= 1'b1;
                  fin_ch <= cur_ch;
               end else begin
                  ptr   <= ptr + AW'(4);
                  state <= ENG_ADDR;
               end
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end

   // R1: a register write only ever follows a memory response
   a_r1_write_after_data: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $past(mem_rvalid));
   // R7: the served channel does not change while the engine stays busy
   a_r7_channel_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cur_ch));
   // R2: the fetch pointer only moves upward by one word on a response
   a_r2_pointer_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(mem_addr)) |-> (mem_addr == $past(mem_addr) + AW'(4)));
endmodule

// File: rtl/vsync_reglist_dma.sv
module vsync_reglist_dma
   import rl_pkg::*;
#(
   parameter int NCH = 2,
   parameter int AW  = 32,
   parameter int DW  = 32,
   parameter int CAW = 6,
   localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [CAW-1:0] cfg_addr,
   input  logic [DW-1:0]  cfg_wdata,
   output logic [DW-1:0]  cfg_rdata,
   input  logic           vsync,
   output logic           mem_req,
   output logic [AW-1:0]  mem_addr,
   input  logic           mem_rvalid,
   input  logic [DW-1:0]  mem_rdata,
   output logic           wr_valid,
   output logic [DW-1:0]  wr_addr,
   output logic [DW-1:0]  wr_data,
   output logic           irq
);
   localparam int NREG = REG_CH_BASE + 2 * NCH;

   generate
      if (NCH < 2)           begin : g_bad_nch  $error("NCH must be at least 2"); end
      if (2 * NCH > DW)      begin : g_bad_dw   $error("trigger register too narrow"); end
      if (NREG > (1 << CAW)) begin : g_bad_caw  $error("CAW too small for map"); end
      if (AW < 3)            begin : g_bad_aw   $error("AW too small"); end
   endgenerate

   logic [DW-1:0]  trig_q;
   logic [NCH-1:0] done_q, pend_q, arm, grant, fin_mask, clr_mask;
   logic [CW-1:0]  grant_idx, cur_ch, fin_ch;
   logic           vs_q, vs_rise, busy, go, fin;
   logic [AW-1:0]  ch_start [NCH];
   logic [AW-1:0]  ch_end   [NCH];

   assign vs_rise = vsync && !vs_q;
   assign go      = !busy && (pend_q != '0);
   assign irq     = (done_q != '0);

   genvar gi;
   generate
      for (gi = 0; gi < NCH; gi++) begin : g_ch
         rl_chan_cfg #(.AW(AW), .DW(DW)) u_cfg (
            .clk       (clk),
            .rst_n     (rst_n),
            .we_start  (cfg_we && (cfg_addr == CAW'(REG_CH_BASE + 2 * gi))),
            .we_end    (cfg_we && (cfg_addr == CAW'(REG_CH_BASE + 2 * gi + 1))),
            .wdata     (cfg_wdata),
            .start_addr(ch_start[gi]),
            .end_addr  (ch_end[gi])
         );
         assign arm[gi] = vs_rise && trig_q[gi] && trig_q[NCH + gi] && !pend_q[gi]
                          && !(busy && (cur_ch == CW'(gi)));
         assign fin_mask[gi] = fin && (fin_ch == CW'(gi));
         assign clr_mask[gi] = cfg_we && (cfg_addr == CAW'(REG_CLR)) && cfg_wdata[gi];

         // R5: completion of a channel's list raises its done bit
         a_r5_done_set: assert property (@(posedge clk) disable iff (!rst_n)
            fin_mask[gi] |=> done_q[gi]);
         // R6: a clear write drops the done bit unless a completion coincides
         a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_mask[gi] && !fin_mask[gi]) |=> !done_q[gi]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q <= '0;
         done_q <= '0;
         pend_q <= '0;
         vs_q   <= 1'b0;
      end else begin
         vs_q   <= vsync;
         if (cfg_we && (cfg_addr == CAW'(REG_TRIG))) trig_q <= cfg_wdata;
         done_q <= (done_q & ~clr_mask) | fin_mask;
         pend_q <= (pend_q | arm) & ~(go ? grant : '0);
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (cfg_addr == CAW'(REG_TRIG)) cfg_rdata = trig_q;
      if (cfg_addr == CAW'(REG_DONE)) cfg_rdata[NCH-1:0] = done_q;
      for (int i = 0; i < NCH; i++) begin
         if (cfg_addr == CAW'(REG_CH_BASE + 2 * i))     cfg_rdata = DW'(ch_start[i]);
         if (cfg_addr == CAW'(REG_CH_BASE + 2 * i + 1)) cfg_rdata = DW'(ch_end[i]);
      end
   end

   rl_arbiter #(.NCH(NCH)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (pend_q),
      .grant    (grant),
      .grant_idx(grant_idx)
   );

   rl_engine #(.AW(AW), .DW(DW), .NCH(NCH)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .go_ch     (grant_idx),
      .go_start  (ch_start[grant_idx]),
      .go_end    (ch_end[grant_idx]),
      .busy      (busy),
      .cur_ch    (cur_ch),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .mem_rvalid(mem_rvalid),
      .mem_rdata (mem_rdata),
      .wr_valid  (wr_valid),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .fin       (fin),
      .fin_ch    (fin_ch)
   );

   // R2: every fetch stays inside the served channel's inclusive window
   a_r2_fetch_window: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr >= ch_start[cur_ch]) && (mem_addr <= ch_end[cur_ch]));
   // R8: a channel that is being served is never pending again at the same time
   a_r8_no_requeue: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !pend_q[cur_ch]);
   // R10: nothing is requested or written while no channel is served
   a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !wr_valid || $past(busy));
endmodule

// File: tb/tb_vsync_reglist_dma.sv
module tb_vsync_reglist_dma;
   localparam int NCH = 2, AW = 32, DW = 32, CAW = 6;

   logic           clk = 1'b0, rst_n = 1'b0;
   logic           cfg_we = 1'b0;
   logic [CAW-1:0] cfg_addr = '0;
   logic [DW-1:0]  cfg_wdata = '0;
   logic [DW-1:0]  cfg_rdata;
   logic           vsync = 1'b0;
   logic           mem_req;
   logic [AW-1:0]  mem_addr;
   logic           mem_rvalid = 1'b0;
   logic [DW-1:0]  mem_rdata = '0;
   logic           wr_valid, irq;
   logic [DW-1:0]  wr_addr, wr_data;

   int errors = 0, checks = 0, nwrites = 0;
   logic [31:0] mem [0:255];
   logic [63:0] exp_q [$];
   bit finished = 0;

   always #10 clk = ~clk;

   vsync_reglist_dma #(.NCH(NCH), .AW(AW), .DW(DW), .CAW(CAW)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .vsync(vsync),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .irq(irq));

   // memory model: answer each request on alternate cycles
   always @(negedge clk) begin
      if (mem_req && !mem_rvalid) begin
         mem_rvalid = 1'b1;
         mem_rdata  = mem[mem_addr[9:2]];
      end else begin
         mem_rvalid = 1'b0;
      end
   end

   // monitor: pop and compare every register write (R1, R4, R7)
   always @(negedge clk) begin
      if (rst_n && wr_valid) begin
         nwrites++;
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R1 unexpected write: got %h=%h expected none", wr_addr, wr_data);
         end else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            if ({wr_addr, wr_data} !== e) begin
               errors++;
               $display("FAIL R1/R4/R7 write: got %h=%h expected %h=%h",
                        wr_addr, wr_data, e[63:32], e[31:0]);
            end
         end
      end
   end

   task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic cfg_write(input int a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = CAW'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input int a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = CAW'(a);
      #1 d = cfg_rdata;
   endtask

   task automatic pulse_vsync();
      @(negedge clk); vsync = 1'b1;
      @(negedge clk); @(negedge clk); vsync = 1'b0;
   endtask

   // driver: build a list in memory and program the channel window
   task automatic build_list(input int ch, input int base, input int n, input int seed);
      for (int k = 0; k < n; k++) begin
         mem[(base >> 2) + 2 * k]     = 32'h0000_0100 + 32'((seed * 37 + k * 91) % 977);
         mem[(base >> 2) + 2 * k + 1] = 32'hA500_0000 ^ 32'(seed * 4096 + k * 17);
      end
      cfg_write(4 + 2 * ch, 32'(base));
      cfg_write(5 + 2 * ch, 32'(base + 8 * n - 4));
   endtask

   task automatic expect_list(input int base, input int n);
      for (int k = 0; k < n; k++)
         exp_q.push_back({mem[(base >> 2) + 2 * k], mem[(base >> 2) + 2 * k + 1]});
   endtask

   task automatic settle(input int cyc);
      repeat (cyc) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      for (int i = 0; i < 256; i++) mem[i] = 32'(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state
      cfg_read(1, rd);
      check(rd, 0, "R10 done after reset");
      check({31'b0, irq}, 0, "R10 irq after reset");
      check({31'b0, mem_req}, 0, "R10 mem_req after reset");
      check({31'b0, wr_valid}, 0, "R10 wr_valid after reset");

      // R1 R2 R4 R5: single channel, scattered target addresses
      build_list(0, 32'h100, 3, 1);
      mem[(32'h100 >> 2) + 0] = 32'h0000_3FF0;
      mem[(32'h100 >> 2) + 2] = 32'h0000_0040;
      mem[(32'h100 >> 2) + 4] = 32'h0000_0123;
      cfg_read(4, rd);
      check(rd, 32'h100, "R2 start register readback");
      cfg_write(0, 32'h5);
      expect_list(32'h100, 3);
      pulse_vsync();
      settle(40);
      check(32'(exp_q.size()), 0, "R1 all ch0 writes seen");
      check(32'(nwrites), 3, "R2 ch0 write count");
      cfg_read(1, rd);
      check(rd, 32'h1, "R5 done bit ch0");
      check({31'b0, irq}, 1, "R5 irq high");

      // R6: clearing a bit that is not set leaves others; then clear ch0
      cfg_write(2, 32'h2);
      cfg_read(1, rd);
      check(rd, 32'h1, "R6 clear of other bit keeps ch0");
      cfg_write(2, 32'h1);
      cfg_read(1, rd);
      check(rd, 32'h0, "R6 done cleared");
      check({31'b0, irq}, 0, "R6 irq dropped");

      // R3: enable without direction, and direction without enable
      nwrites = 0;
      cfg_write(0, 32'h1);
      pulse_vsync();
      settle(30);
      cfg_write(0, 32'h4);
      pulse_vsync();
      settle(30);
      check(32'(nwrites), 0, "R3 no writes when not fully armed");
      cfg_read(1, rd);
      check(rd, 32'h0, "R3 no done when not fully armed");

      // R7: both channels on one edge, ch0 list completes before ch1
      build_list(0, 32'h100, 2, 5);
      build_list(1, 32'h200, 2, 9);
      cfg_write(0, 32'hF);
      expect_list(32'h100, 2);
      expect_list(32'h200, 2);
      pulse_vsync();
      cfg_write(0, 32'h0);
      settle(60);
      check(32'(exp_q.size()), 0, "R7 both lists in order");
      cfg_read(1, rd);
      check(rd, 32'h3, "R7 both done");
      cfg_write(2, 32'h3);

      // R8: second edge during a run is ignored
      nwrites = 0;
      build_list(1, 32'h200, 6, 3);
      cfg_write(0, 32'hA);
      expect_list(32'h200, 6);
      pulse_vsync();
      settle(6);
      pulse_vsync();
      settle(80);
      check(32'(exp_q.size()), 0, "R8 list ran once");
      check(32'(nwrites), 6, "R8 no second run");
      cfg_read(1, rd);
      check(rd, 32'h2, "R8 done ch1");

      // R11: enable left set, next edge replays the list
      cfg_write(2, 32'h2);
      nwrites = 0;
      expect_list(32'h200, 6);
      pulse_vsync();
      settle(80);
      check(32'(nwrites), 6, "R11 replay count");
      check(32'(exp_q.size()), 0, "R11 replay content");
      cfg_write(0, 32'h0);
      cfg_write(2, 32'h3);

      // R9: end below start
      nwrites = 0;
      cfg_write(4, 32'h180);
      cfg_write(5, 32'h17C);
      cfg_write(0, 32'h5);
      pulse_vsync();
      settle(10);
      cfg_write(0, 32'h0);
      check(32'(nwrites), 0, "R9 no writes on empty window");
      cfg_read(1, rd);
      check(rd, 32'h1, "R9 done set on empty window");
      check({31'b0, mem_req}, 0, "R9 no memory request");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule